// File: doc/BRIEF.md
# Multi-Mode Tick Timer

This block is a free-running cycle counter paired with a control word that selects what happens when the counter reaches a programmed period. Software loads either register through a single write port and reads either one back through a read select. The control word holds a two-bit mode, an interrupt enable, a sticky pending flag and a 28-bit period. On every cycle the low 28 bits of the counter are compared with the period.

The four modes are idle, reload, single-shot and free-run. In idle the count is held. In reload the counter returns to zero at the match. In single-shot the counter stops at the period and holds there. In free-run the counter keeps going and matches once every time its low bits come round to the period. A match while the interrupt enable is set raises the pending flag. Only software can clear that flag. The interrupt request output follows the pending flag, gated by an enable input from the processor.

Top module: `tick_timer`

## Requirements
- R1: After reset, the counter reads 0, the control word reads 0 and `irq_o` is low.
- R2: In idle mode (mode bits 31:30 = 00), the counter holds its value. A match, meaning that the count's low 28 bits equal the period, still raises pending when the enable is set.
- R3: In reload mode (01), a count whose low bits equal the period becomes 0 on the next cycle. Counting then continues, so the count never passes the period.
- R4: In single-shot mode (10), the counter increments until it equals the period. It then stays frozen at that value.
- R5: In free-run mode (11), the full 32-bit counter increments on every cycle. It carries past the 28-bit boundary into bits 31:28, and a match is raised each time the low 28 bits equal the period.
- R6: A control-word write with bit 28 = 1 leaves pending unchanged, and a write with bit 28 = 0 clears it. Without a write, pending stays set.
- R7: The control word layout is as follows: bits 31:30 are the mode, bit 29 is the interrupt enable, bit 28 is pending and bits 27:0 are the period. Hardware sets pending on a match while the enable is set. If hardware sets pending in the same cycle that software clears it, the hardware set wins.
- R8: `irq_o` is high exactly while pending is set and `tick_en_i` is high.
- R9: Writing single-shot mode while the count already equals the period leaves the counter stopped.
- R10: A counter write loads the written value at that clock edge and overrides the increment. A control-word write is used by the compare from the next cycle onward.
- R11: A match produces a single event. A count that stays equal to the period, as in single-shot or idle mode, sets pending only once, so pending stays clear after software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 counter, 1 control word |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read source: 0 counter, 1 control word |
| rd_data_o | output | 32 | Read data, combinational from the registers |
| tick_en_i | input | 1 | Processor-side interrupt enable |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench targets a single-shot counter that has frozen at the period. A design that re-detects that match would set pending again right after software clears it. A rewrite of single-shot mode on a frozen count is also tested: a design that restarts would run past the period. A free-run count is loaded just below the 28-bit boundary, which shows up a design that truncates the counter or matches on all 32 bits. Writes of 1 to the pending bit must not raise it, the tick enable input must mask the request, and reload mode must never let the count pass the period.

// File: rtl/tick_pkg.sv
package tick_pkg;
   typedef enum logic [1:0] {
      TM_IDLE   = 2'b00,
      TM_RELOAD = 2'b01,
      TM_SINGLE = 2'b10,
      TM_FREE   = 2'b11
   } tmode_e;
endpackage

// File: rtl/tick_match.sv
module tick_match #(
   parameter int CNT_W = 32,
   parameter int PER_W = 28
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [PER_W-1:0] period_i,
   output logic             hit_o,
   output logic             hit_pulse_o
);
   logic hit_q;

   if (PER_W > CNT_W) begin : g_bad_width
      $error("tick_match: PER_W exceeds CNT_W");
   end

   assign hit_o       = (cnt_i[PER_W-1:0] == period_i);
   assign hit_pulse_o = hit_o & ~hit_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hit_q <= 1'b0;
      else         hit_q <= hit_o;
   end

   // R11
   no_double_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_pulse_o && $stable(cnt_i) && $stable(period_i)) |=> !hit_pulse_o);
endmodule

// File: rtl/tick_count.sv
module tick_count import tick_pkg::*; #(
   parameter int CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  tmode_e           mode_i,
   input  logic             hit_i,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] ld_val_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

   assign cnt_inc = cnt_q + ONE;

   always_comb begin
      unique case (mode_i)
         TM_IDLE:   cnt_d = cnt_q;
         TM_RELOAD: cnt_d = hit_i ? '0 : cnt_inc;
         TM_SINGLE: cnt_d = hit_i ? cnt_q : cnt_inc;
         TM_FREE:   cnt_d = cnt_inc;
         default:   cnt_d = cnt_q;
      endcase
      if (ld_i) cnt_d = ld_val_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign cnt_o = cnt_q;

   // R4
   single_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == TM_SINGLE && hit_i && !ld_i) |=> $stable(cnt_q));
   // R3
   reload_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == TM_RELOAD && hit_i && !ld_i) |=> (cnt_q == '0));
   // R2
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == TM_IDLE && !ld_i) |=> $stable(cnt_q));
   // R10
   load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_i |=> (cnt_q == $past(ld_val_i)));
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl import tick_pkg::*; #(
   parameter int CNT_W = 32,
   parameter int PER_W = 28
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             hit_pulse_i,
   input  logic             tick_en_i,
   output tmode_e           mode_o,
   output logic [PER_W-1:0] period_o,
   output logic [CNT_W-1:0] word_o,
   output logic             irq_o
);
   localparam int MODE_HI = CNT_W - 1;
   localparam int MODE_LO = CNT_W - 2;
   localparam int IE_B    = CNT_W - 3;
   localparam int IP_B    = CNT_W - 4;
   localparam int RSV_W   = IP_B - PER_W;

   if (PER_W > IP_B) begin : g_bad_period
      $error("tick_ctrl: period field overlaps flag bits");
   end

   tmode_e           mode_q;
   logic             ie_q, ip_q, ip_d;
   logic [PER_W-1:0] per_q;

   always_comb begin
      ip_d = ip_q;
      if (wr_i) ip_d = ip_q & wr_data_i[IP_B];
      if (hit_pulse_i && ie_q) ip_d = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= TM_IDLE;
         ie_q   <= 1'b0;
         ip_q   <= 1'b0;
         per_q  <= '0;
      end else begin
         ip_q <= ip_d;
         if (wr_i) begin
            mode_q <= tmode_e'(wr_data_i[MODE_HI:MODE_LO]);
            ie_q   <= wr_data_i[IE_B];
            per_q  <= wr_data_i[PER_W-1:0];
         end
      end
   end

   if (RSV_W > 0) begin : g_rsv
      assign word_o = {mode_q, ie_q, ip_q, {RSV_W{1'b0}}, per_q};
   end else begin : g_norsv
      assign word_o = {mode_q, ie_q, ip_q, per_q};
   end

   assign mode_o   = mode_q;
   assign period_o = per_q;
   assign irq_o    = ip_q & tick_en_i;

   // R6
   pend_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ip_q && !wr_i) |=> ip_q);
   // R7
   pend_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ip_q) |-> $past(hit_pulse_i && ie_q));
   // R6
   pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !wr_data_i[IP_B] && !(hit_pulse_i && ie_q)) |=> !ip_q);
endmodule

// File: rtl/tick_timer.sv
module tick_timer import tick_pkg::*; #(
   parameter int CNT_W = 32,
   parameter int PER_W = 28
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic             wr_sel_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic             rd_sel_i,
   output logic [CNT_W-1:0] rd_data_o,
   input  logic             tick_en_i,
   output logic             irq_o
);
   if (CNT_W < 8) begin : g_bad_cnt
      $error("tick_timer: CNT_W too small");
   end

   tmode_e           mode;
   logic [PER_W-1:0] period;
   logic [CNT_W-1:0] cnt, word;
   logic             hit, hit_pulse;

   tick_match #(.CNT_W(CNT_W), .PER_W(PER_W)) i_match (
      .clk_i(clk_i), .rst_ni(rst_ni), .cnt_i(cnt), .period_i(period),
      .hit_o(hit), .hit_pulse_o(hit_pulse)
   );

   tick_count #(.CNT_W(CNT_W)) i_count (
      .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .hit_i(hit),
      .ld_i(wr_en_i & ~wr_sel_i), .ld_val_i(wr_data_i), .cnt_o(cnt)
   );

   tick_ctrl #(.CNT_W(CNT_W), .PER_W(PER_W)) i_ctrl (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_en_i & wr_sel_i),
      .wr_data_i(wr_data_i), .hit_pulse_i(hit_pulse), .tick_en_i(tick_en_i),
      .mode_o(mode), .period_o(period), .word_o(word), .irq_o(irq_o)
   );

   assign rd_data_o = rd_sel_i ? word : cnt;
endmodule

// File: tb/test_tick_timer.sv
module test_tick_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, tick_en = 1'b1;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq;

   int checks = 0, errors = 0, cyc = 0;
   string cur_req = "R1";

   logic [31:0] m_cnt = '0, m_mode = '0;
   logic        m_prev = 1'b0;

   always #4 clk = ~clk;

   tick_timer i_tick_timer (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
      .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
      .tick_en_i(tick_en), .irq_o(irq)
   );

   // behavioural reference, updated on each rising edge
   always @(posedge clk) begin
      logic        match, ev;
      logic [31:0] n_cnt, n_mode;
      if (!rst_n) begin
         m_cnt = '0; m_mode = '0; m_prev = 1'b0;
      end else begin
         match = (m_cnt[27:0] == m_mode[27:0]);
         ev    = match && !m_prev;
         n_cnt = m_cnt;
         if (m_mode[31:30] == 2'd1) n_cnt = match ? 32'd0 : m_cnt + 32'd1;
         if (m_mode[31:30] == 2'd2) n_cnt = match ? m_cnt : m_cnt + 32'd1;
         if (m_mode[31:30] == 2'd3) n_cnt = m_cnt + 32'd1;
         if (wr_en && !wr_sel) n_cnt = wr_data;
         n_mode = m_mode;
         if (wr_en && wr_sel) begin
            n_mode = wr_data;
            n_mode[28] = wr_data[28] & m_mode[28];
         end
         if (ev && m_mode[29]) n_mode[28] = 1'b1;
         m_prev = match;
         m_cnt  = n_cnt;
         m_mode = n_mode;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      #2;
      if (rst_n) begin
         check(cur_req, rd_data, rd_sel ? m_mode : m_cnt);
         check(cur_req, {31'd0, irq}, {31'd0, m_mode[28] & tick_en});
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic wr(input logic sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic peek(input logic sel, output logic [31:0] v);
      rd_sel = sel;
      #2;
      v = rd_data;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      logic [31:0] mx;
      logic        saw_zero;
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      peek(1'b0, v); check("R1", v, 32'h0);
      peek(1'b1, v); check("R1", v, 32'h0);
      check("R1", {31'd0, irq}, 32'd0);

      // R2 idle mode holds the count
      cur_req = "R2";
      wr(1'b0, 32'd7);
      idle(5);
      peek(1'b0, v); check("R2", v, 32'd7);
      // R7 match while idle with enable set raises pending
      cur_req = "R7";
      wr(1'b1, 32'h2000_0007);
      idle(2);
      peek(1'b1, v); check("R7", v, 32'h3000_0007);
      // R8 gating of the request
      cur_req = "R8";
      check("R8", {31'd0, irq}, 32'd1);
      @(negedge clk); tick_en = 1'b0; #2;
      check("R8", {31'd0, irq}, 32'd0);
      @(negedge clk); tick_en = 1'b1;
      // R6 writing 1 keeps, writing 0 clears
      cur_req = "R6";
      wr(1'b1, 32'h3000_0007);
      peek(1'b1, v); check("R6", v, 32'h3000_0007);
      wr(1'b1, 32'h2000_0007);
      idle(5);
      // R11 held match does not re-raise pending
      peek(1'b1, v); check("R11", v, 32'h2000_0007);

      // R4 single-shot stops at the period
      cur_req = "R4";
      wr(1'b0, 32'd0);
      wr(1'b1, 32'hA000_0006);
      idle(15);
      peek(1'b0, v); check("R4", v, 32'd6);
      peek(1'b1, v); check("R4", v, 32'hB000_0006);
      // R9 rewriting single-shot on a frozen count keeps it stopped
      cur_req = "R9";
      wr(1'b1, 32'hA000_0006);
      idle(5);
      peek(1'b0, v); check("R9", v, 32'd6);
      peek(1'b1, v); check("R11", v, 32'hA000_0006);

      // R5 free-run carries across the 28-bit boundary
      cur_req = "R5";
      wr(1'b1, 32'hE000_0003);
      wr(1'b0, 32'h0FFF_FFFC);
      idle(10);
      peek(1'b0, v); check("R5", {28'd0, v[31:28]}, 32'd1);
      peek(1'b1, v); check("R5", v, 32'hF000_0003);
      // R10 counter write overrides the increment
      cur_req = "R10";
      wr(1'b0, 32'h55);
      peek(1'b0, v); check("R10", v, 32'h55);

      // R3 reload never passes the period
      cur_req = "R3";
      wr(1'b0, 32'd0);
      wr(1'b1, 32'h4000_0004);
      mx = '0; saw_zero = 1'b0;
      for (int i = 0; i < 15; i++) begin
         idle(1);
         peek(1'b0, v);
         if (v > mx) mx = v;
         if (v == 32'd0 && mx == 32'd4) saw_zero = 1'b1;
      end
      check("R3", mx, 32'd4);
      check("R3", {31'd0, saw_zero}, 32'd1);

      idle(4);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule